// File: doc/BRIEF.md
# Opcode Page Stack Controller

This block keeps track of which alternate opcode page is in force for compact instructions. A page-select instruction pushes an entry onto a small stack. Each entry names a subpage and an activation length. The page on top of the stack is the one that applies. Decoding the instructions themselves is left to the surrounding pipeline, which only tells the block about retirements, taken branches and the page commands it has decoded.

The length on the top entry counts down by one for each retired instruction. The entry leaves the stack when its count runs out. A length of all ones marks an entry as permanent: it never counts down. A taken branch discards temporary entries from the top down and stops at the first permanent one. Two commands act on the whole stack: one empties it, returning to the default instruction set, and the other drops only the top level.

The whole state fits in one 32-bit control/status register, so software can save it and restore it across a context switch. The commands and the register port are plain single-cycle strobes; nothing at this block's boundary carries a data stream, so there is no valid/ready handshake and no back-pressure. At most one action takes effect per clock, chosen by a fixed priority.

Top module: `opg_stack_ctrl`

## Requirements
- R1: After reset the stack is empty, the overflow flag is 0, `csr_rdata_o` reads 0, `page_valid_o` is 0 and `page_o` is 0.
- R2: A push at depth below 4 writes {`push_page_i`, `push_len_i`} into the next free slot and raises the depth by one. The next cycle, `page_valid_o` is 1 and `page_o` shows the pushed page. When the depth is 0, `page_valid_o` is 0, meaning the default set applies, and `page_o` reads 0.
- R3: A push at depth 4 leaves the entries and the depth unchanged and sets the overflow flag. The flag stays set until reset or until a register write clears it.
- R4: A retire strobe with a non-permanent top entry lowers that entry's length by one. If the length is 1 or 0, the top entry is popped instead.
- R5: A retire strobe has no effect when the top entry's length is 4'b1111 (permanent) or when the stack is empty.
- R6: A taken branch pops every entry from the top down until it reaches the first entry with length 4'b1111, which stays on the stack along with everything below it. With no permanent entry, the stack empties.
- R7: A pop removes exactly the top entry. A pop at depth 0 has no effect.
- R8: A clear empties the stack and leaves the overflow flag unchanged.
- R9: Register layout: entry i occupies bits [7i+6:7i], with the page in the upper 3 bits and the length in the lower 4; entry 0 is the bottom of the stack. Bits [30:28] hold the depth and bit 31 holds the overflow flag. A write loads all fields, and a written depth above 4 is taken as 4.
- R10: When several strobes arrive in the same cycle, only one acts, chosen in this order: register write, clear, branch, pop, push, retire.
- R11: Slots at or above the current depth always read as zero, including slots that were given nonzero values in a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| branch_i | input | 1 | A branch was taken this cycle |
| push_i | input | 1 | Page-select command |
| push_page_i | input | 3 | Subpage number to push |
| push_len_i | input | 4 | Activation length to push; 4'b1111 means permanent |
| pop_i | input | 1 | Drop the top level |
| clr_i | input | 1 | Return to the default instruction set |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register contents |
| page_valid_o | output | 1 | 1 when an alternate page is active |
| page_o | output | 3 | Subpage number of the top entry |

## Verification
The bench checks that a branch stops at a permanent entry that sits below temporary ones; a design that scanned from the bottom, or popped only one entry, would leave the wrong depth. It retires on top entries with lengths of 1 and 0, where a design off by one would keep a dead page alive for an extra instruction. It pushes onto a full stack and then keeps working, because a lost sticky flag or a corrupted slot would show up in the register read-back. It also writes out-of-range depths and stale slots, and fires several strobes in the same cycle; a wrong priority or a missing clamp changes the register value seen on the next cycle.

// File: rtl/opg_pkg.sv
package opg_pkg;
  localparam int PG_W    = 3;
  localparam int LEN_W   = 4;
  localparam int ENT_W   = PG_W + LEN_W;
  localparam int STACK_N = 4;

  typedef struct packed {
    logic [PG_W-1:0]  pg;
    logic [LEN_W-1:0] len;
  } opg_entry_t;

  localparam logic [LEN_W-1:0] LEN_PERM = '1;
endpackage

// File: rtl/opg_expire.sv
module opg_expire
  import opg_pkg::*;
(
  input  logic [LEN_W-1:0] len_i,
  output logic             perm_o,
  output logic             expire_o,
  output logic [LEN_W-1:0] dec_len_o
);
  always_comb begin
    perm_o    = (len_i == LEN_PERM);
    expire_o  = !perm_o && (len_i <= LEN_W'(1));
    dec_len_o = len_i - LEN_W'(1);
  end
endmodule

// File: rtl/opg_branch_scan.sv
module opg_branch_scan
  import opg_pkg::*;
#(
  parameter int DEPTH = STACK_N,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  opg_entry_t [DEPTH-1:0] ent_i,
  input  logic [CNT_W-1:0]       dep_i,
  output logic [CNT_W-1:0]       keep_o
);
  // highest permanent slot below the current depth sets the surviving depth
  always_comb begin
    keep_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < dep_i) && (ent_i[i].len == LEN_PERM))
        keep_o = CNT_W'(i + 1);
    end
  end
endmodule

// File: rtl/opg_csr_codec.sv
module opg_csr_codec
  import opg_pkg::*;
#(
  parameter int DEPTH = STACK_N,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CSR_W = DEPTH * ENT_W + CNT_W + 1,
  localparam int DEP_LO = DEPTH * ENT_W
) (
  input  opg_entry_t [DEPTH-1:0] ent_i,
  input  logic [CNT_W-1:0]       dep_i,
  input  logic                   ovf_i,
  output logic [CSR_W-1:0]       rdata_o,
  input  logic [CSR_W-1:0]       wdata_i,
  output opg_entry_t [DEPTH-1:0] w_ent_o,
  output logic [CNT_W-1:0]       w_dep_o,
  output logic                   w_ovf_o
);
  logic [CNT_W-1:0] raw_dep;

  always_comb begin
    rdata_o = {ovf_i, dep_i, ent_i};
  end

  always_comb begin
    raw_dep = wdata_i[DEP_LO +: CNT_W];
    w_dep_o = (raw_dep > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : raw_dep;
    w_ovf_o = wdata_i[CSR_W-1];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    always_comb begin
      if (CNT_W'(g) < w_dep_o) w_ent_o[g] = wdata_i[g*ENT_W +: ENT_W];
      else                     w_ent_o[g] = '0;
    end
  end
endmodule

// File: rtl/opg_stack_ctrl.sv
module opg_stack_ctrl
  import opg_pkg::*;
#(
  parameter int DEPTH = STACK_N,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CSR_W = DEPTH * ENT_W + CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              branch_i,
  input  logic              push_i,
  input  logic [PG_W-1:0]   push_page_i,
  input  logic [LEN_W-1:0]  push_len_i,
  input  logic              pop_i,
  input  logic              clr_i,
  input  logic              csr_we_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  csr_rdata_o,
  output logic              page_valid_o,
  output logic [PG_W-1:0]   page_o
);
  opg_entry_t [DEPTH-1:0] ent_q, ent_d, w_ent;
  logic [CNT_W-1:0]       dep_q, dep_d, w_dep, keep_dep;
  logic                   ovf_q, ovf_d, w_ovf;
  opg_entry_t             top_ent;
  logic                   top_perm, top_expire;
  logic [LEN_W-1:0]       top_dec;

  // one-hot view of the action selected this cycle
  logic act_wr, act_clr, act_br, act_pop, act_push, act_ret;

  always_comb begin
    act_wr   = csr_we_i;
    act_clr  = !act_wr && clr_i;
    act_br   = !act_wr && !clr_i && branch_i;
    act_pop  = !act_wr && !clr_i && !branch_i && pop_i;
    act_push = !act_wr && !clr_i && !branch_i && !pop_i && push_i;
    act_ret  = !act_wr && !clr_i && !branch_i && !pop_i && !push_i && retire_i;
  end

  always_comb begin
    top_ent = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CNT_W'(i + 1) == dep_q) top_ent = ent_q[i];
  end

  opg_expire u_exp (
    .len_i     (top_ent.len),
    .perm_o    (top_perm),
    .expire_o  (top_expire),
    .dec_len_o (top_dec)
  );

  opg_branch_scan #(.DEPTH(DEPTH)) u_scan (
    .ent_i  (ent_q),
    .dep_i  (dep_q),
    .keep_o (keep_dep)
  );

  opg_csr_codec #(.DEPTH(DEPTH)) u_csr (
    .ent_i   (ent_q),
    .dep_i   (dep_q),
    .ovf_i   (ovf_q),
    .rdata_o (csr_rdata_o),
    .wdata_i (csr_wdata_i),
    .w_ent_o (w_ent),
    .w_dep_o (w_dep),
    .w_ovf_o (w_ovf)
  );

  always_comb begin
    ent_d = ent_q;
    dep_d = dep_q;
    ovf_d = ovf_q;
    if (act_wr) begin
      ent_d = w_ent;
      dep_d = w_dep;
      ovf_d = w_ovf;
    end else if (act_clr) begin
      ent_d = '0;
      dep_d = '0;
    end else if (act_br) begin
      for (int i = 0; i < DEPTH; i++)
        if (CNT_W'(i) >= keep_dep) ent_d[i] = '0;
      dep_d = keep_dep;
    end else if (act_pop) begin
      if (dep_q != '0) begin
        for (int i = 0; i < DEPTH; i++)
          if (CNT_W'(i + 1) == dep_q) ent_d[i] = '0;
        dep_d = dep_q - CNT_W'(1);
      end
    end else if (act_push) begin
      if (dep_q == CNT_W'(DEPTH)) begin
        ovf_d = 1'b1;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (CNT_W'(i) == dep_q) ent_d[i] = '{pg: push_page_i, len: push_len_i};
        dep_d = dep_q + CNT_W'(1);
      end
    end else if (act_ret && dep_q != '0 && !top_perm) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i + 1) == dep_q) begin
          if (top_expire) ent_d[i] = '0;
          else            ent_d[i].len = top_dec;
        end
      end
      if (top_expire) dep_d = dep_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      dep_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ent_q <= ent_d;
      dep_q <= dep_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    page_valid_o = (dep_q != '0);
    page_o       = top_ent.pg;
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dep_q <= CNT_W'(DEPTH)); // R9

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_STALE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W'(g) >= dep_q) |-> (ent_q[g] == '0)); // R11
  end

  AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (act_push && dep_q == CNT_W'(DEPTH)) |=> (ovf_q && $stable(ent_q) && $stable(dep_q))); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !csr_we_i) |=> ovf_q); // R3

  AST_PERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ret && top_perm) |=> ($stable(ent_q) && $stable(dep_q))); // R5

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pop && dep_q != '0) |=> (dep_q == $past(dep_q) - CNT_W'(1))); // R7

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    act_clr |=> (dep_q == '0 && ovf_q == $past(ovf_q))); // R8

  AST_BR_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    act_br |=> (dep_q <= $past(dep_q))); // R6
endmodule

// File: tb/sim_opg_stack_ctrl.sv
`timescale 1ns/1ps
module sim_opg_stack_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_i = 0, branch_i = 0, push_i = 0, pop_i = 0, clr_i = 0, csr_we_i = 0;
  logic [2:0]  push_page_i = '0;
  logic [3:0]  push_len_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        page_valid_o;
  logic [2:0]  page_o;

  always #2 clk = ~clk;

  opg_stack_ctrl u0 (.*);

  typedef struct {
    logic [31:0] csr;
    logic        v;
    logic [2:0]  pg;
    string       tag;
  } exp_t;
  exp_t q[$];

  int tests = 0, fails = 0;
  bit done = 0;
  int m_pg[4], m_len[4], m_dep;
  bit m_ovf;

  function automatic logic [31:0] model_csr();
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) r[7*i +: 7] = {3'(m_pg[i]), 4'(m_len[i])};
    r[30:28] = 3'(m_dep);
    r[31] = m_ovf;
    return r;
  endfunction

  task automatic check(input logic [31:0] c, input logic v, input logic [2:0] p,
                       input exp_t e);
    tests++;
    if (c !== e.csr || v !== e.v || p !== e.pg) begin
      fails++;
      $display("FAIL %s: csr=%h valid=%b page=%0d expected csr=%h valid=%b page=%0d",
               e.tag, c, v, p, e.csr, e.v, e.pg);
    end
  endtask

  function automatic exp_t model_exp(string tag);
    exp_t e;
    e.csr = model_csr();
    e.v   = (m_dep != 0);
    e.pg  = (m_dep != 0) ? 3'(m_pg[m_dep-1]) : 3'd0;
    e.tag = tag;
    return e;
  endfunction

  // driver: drive one cycle of strobes, update the reference model, queue the expectation
  task automatic step(input bit re, br, pu, po, cl, we, input int pg, ln,
                      input logic [31:0] wd, input string tag);
    @(negedge clk);
    retire_i = re; branch_i = br; push_i = pu; pop_i = po; clr_i = cl; csr_we_i = we;
    push_page_i = 3'(pg); push_len_i = 4'(ln); csr_wdata_i = wd;
    if (we) begin
      m_dep = int'(wd[30:28]);
      if (m_dep > 4) m_dep = 4;
      for (int i = 0; i < 4; i++) begin
        m_pg[i]  = (i < m_dep) ? int'(wd[7*i+4 +: 3]) : 0;
        m_len[i] = (i < m_dep) ? int'(wd[7*i +: 4]) : 0;
      end
      m_ovf = wd[31];
    end else if (cl) begin
      m_dep = 0;
      for (int i = 0; i < 4; i++) begin m_pg[i] = 0; m_len[i] = 0; end
    end else if (br) begin
      int k = 0;
      for (int i = 0; i < m_dep; i++) if (m_len[i] == 15) k = i + 1;
      for (int i = k; i < 4; i++) begin m_pg[i] = 0; m_len[i] = 0; end
      m_dep = k;
    end else if (po) begin
      if (m_dep > 0) begin m_dep--; m_pg[m_dep] = 0; m_len[m_dep] = 0; end
    end else if (pu) begin
      if (m_dep == 4) m_ovf = 1;
      else begin m_pg[m_dep] = pg; m_len[m_dep] = ln; m_dep++; end
    end else if (re && m_dep > 0) begin
      int t = m_dep - 1;
      if (m_len[t] != 15) begin
        if (m_len[t] <= 1) begin m_pg[t] = 0; m_len[t] = 0; m_dep--; end
        else m_len[t]--;
      end
    end
    q.push_back(model_exp(tag));
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    retire_i = 0; branch_i = 0; push_i = 0; pop_i = 0; clr_i = 0; csr_we_i = 0;
  endtask

  // monitor: compares each queued expectation just after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) check(csr_rdata_o, page_valid_o, page_o, q.pop_front());
    end
  end

  initial begin
    #80000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    exp_t e0;
    m_dep = 0; m_ovf = 0;
    for (int i = 0; i < 4; i++) begin m_pg[i] = 0; m_len[i] = 0; end
    repeat (3) @(negedge clk);
    e0 = model_exp("R1 reset state");
    check(csr_rdata_o, page_valid_o, page_o, e0);
    rst_n = 1'b1;

    step(0,0,1,0,0,0, 5,3, 0, "R2 push page 5 len 3");
    step(1,0,0,0,0,0, 0,0, 0, "R4 retire 3->2");
    step(1,0,0,0,0,0, 0,0, 0, "R4 retire 2->1");
    step(1,0,0,0,0,0, 0,0, 0, "R4 retire at 1 pops");
    step(1,0,0,0,0,0, 0,0, 0, "R5 retire on empty stack");
    step(0,0,1,0,0,0, 2,15, 0, "R2 push permanent page 2");
    step(1,0,0,0,0,0, 0,0, 0, "R5 retire on permanent top");
    step(0,0,1,0,0,0, 3,2, 0, "R2 push page 3");
    step(0,0,1,0,0,0, 4,1, 0, "R2 push page 4");
    step(0,0,1,0,0,0, 6,5, 0, "R2 push to depth 4");
    step(0,0,1,0,0,0, 7,7, 0, "R3 push on full stack");
    step(1,0,0,0,0,0, 0,0, 0, "R4 retire after overflow");
    step(0,1,0,0,0,0, 0,0, 0, "R6 branch stops at permanent");
    step(0,1,0,0,0,0, 0,0, 0, "R6 branch with permanent top");
    step(0,0,0,1,0,0, 0,0, 0, "R7 pop one level");
    step(0,0,0,1,0,0, 0,0, 0, "R7 pop on empty stack");
    step(0,0,1,0,0,0, 1,4, 0, "R2 push page 1");
    step(0,0,1,0,0,0, 5,6, 0, "R2 push page 5");
    step(0,1,0,0,0,0, 0,0, 0, "R6 branch with no permanent");
    step(0,0,1,0,0,0, 1,4, 0, "R2 push before clear");
    step(0,0,0,0,1,0, 0,0, 0, "R8 clear keeps overflow flag");
    step(0,0,0,0,0,1, 0,0, {1'b0,3'd7,7'h2F,7'h1A,7'h35,7'h4F}, "R9 write depth clamp");
    step(0,0,0,0,0,1, 0,0, {1'b1,3'd2,7'h2F,7'h1A,7'h35,7'h4F}, "R11 write clears upper slots");
    step(0,0,0,0,0,0, 0,0, 0, "R9 read back written value");
    step(0,0,1,0,1,0, 6,3, 0, "R10 clear beats push");
    step(0,0,1,0,0,0, 6,15, 0, "R2 push permanent page 6");
    step(0,0,1,0,0,0, 3,4, 0, "R2 push page 3");
    step(0,1,0,1,0,0, 0,0, 0, "R10 branch beats pop");
    step(1,0,1,0,0,0, 2,0, 0, "R10 push beats retire");
    step(1,0,0,0,0,0, 0,0, 0, "R4 retire on length 0 pops");
    step(0,0,0,0,1,1, 0,0, {1'b0,3'd1,7'h00,7'h00,7'h00,7'h52}, "R10 write beats clear");
    step(1,0,0,0,0,0, 0,0, 0, "R4 retire 2->1 after write");
    idle();
    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule